// File: doc/BRIEF.md
# Kernel Control Register File

This block is the host-facing register slave of an accelerator kernel. It uses an AXI4-Lite interface with 12 address bits and 32 data bits. The host writes a scalar argument and two 64-bit buffer base addresses into it. It then starts the kernel by setting a bit in the control word, and learns that the kernel has finished either by polling the same word or by taking an interrupt. The compute engine next to it sees a one-cycle start pulse and the argument values as plain outputs. The engine reports back through a done pulse and an idle level.

The control word combines a start bit, a done bit and an idle bit. The start bit clears itself when the engine finishes, and a host read of the word clears the done bit. Two interrupt sources, job finished and job accepted, are latched in a status register that the host clears by writing 1. A per-source enable mask and a global enable gate these status bits onto a level interrupt line. The write address and write data channels are independent and may arrive in any order. Byte strobes apply to every argument word.

Top module: `kctl_regs`

## Requirements
- R1: Writing 1 to bit 0 of offset 0x00 with byte strobe 0 set, while the start bit is 0 and the engine is idle, sets the start bit. It also drives `eng_start` high for exactly one cycle.
- R2: The start bit returns to 0 when `eng_done` pulses. A start write made while the start bit is 1 or the engine is not idle produces no pulse on `eng_start`.
- R3: Bit 1 of offset 0x00 (done) is set by an `eng_done` pulse. Any read of offset 0x00 returns its value and clears it, unless a new done pulse arrives in that cycle.
- R4: Bit 2 of offset 0x00 (idle) is the engine idle level delayed by one register. When the engine raises idle together with its done pulse, the idle bit and the done bit become visible in the same cycle.
- R5: Offset 0x0C is the interrupt status. A done pulse sets bit 0, and an accepted start sets bit 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R6: `irq` is high exactly when bit 0 of offset 0x04 (global enable) is 1 and some status bit is set whose enable bit in offset 0x08 is also 1.
- R7: Offset 0x10 holds the 32-bit scalar. Offsets 0x18 (low word) and 0x1C (high word) hold base address A. Offsets 0x24 (low word) and 0x28 (high word) hold base address B. Each write updates only the bytes whose strobe bit is set.
- R8: Writes to any other offset complete with response OKAY (0) and change nothing. Reads of any other offset return 0 with response OKAY.
- R9: The address and data write channels may be accepted in either order. The write response is raised only after both have been accepted. Once raised, a response (write or read) is held with stable read data until the host takes it.
- R10: After reset all registers are 0, `irq`, `eng_start`, `s_bvalid` and `s_rvalid` are low, and both write channels are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 12 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 12 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_idle | input | 1 | Engine idle level |
| arg_scalar | output | 32 | Scalar argument |
| arg_base_a | output | 64 | Base address of vector A |
| arg_base_b | output | 64 | Base address of vector B |
| irq | output | 1 | Level interrupt to the host |

## Verification
The embedded properties take several things for granted about the inputs:
- the host keeps each valid asserted with stable payload until the matching ready is seen;
- the engine pulses `eng_done` for a single cycle, and only after a start;
- the engine raises `eng_idle` in the same cycle as that pulse.

The directed stimulus respects these rules. Its bus tasks hold valid until they observe ready. A bench-side engine drops idle after the start pulse and later drives done and idle together on one falling edge. The busy-start case is produced only while that engine model is holding idle low.

// File: rtl/kctl_regs.sv
module kctl_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NSRC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_idle,
  output logic [DATA_W-1:0] arg_scalar,
  output logic [2*DATA_W-1:0] arg_base_a,
  output logic [2*DATA_W-1:0] arg_base_b,
  output logic              irq
);
  localparam int STRB_W = DATA_W / 8;
  localparam int LSB    = $clog2(STRB_W);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_GIE  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_IER  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_ISR  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_SCAL = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_ALO  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] OFS_AHI  = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] OFS_BLO  = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] OFS_BHI  = ADDR_W'(12'h028);

  logic              aw_full, w_full, bvalid_q, rvalid_q;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q, rdata_q, rd_mux;
  logic [STRB_W-1:0] w_strb_q;
  logic              start_bit, done_bit, idle_q, gie_bit, start_q;
  logic [NSRC-1:0]   ier_q, isr_q, isr_ev, isr_clr;
  logic [DATA_W-1:0] scalar_q, a_lo, a_hi, b_lo, b_hi;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int i = 0; i < STRB_W; i++)
      if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction

  logic [ADDR_W-1:0] wa, ra;
  assign wa = {aw_addr_q[ADDR_W-1:LSB], {LSB{1'b0}}};
  assign ra = {s_araddr[ADDR_W-1:LSB], {LSB{1'b0}}};

  logic commit, rd_fire, rd_ctrl, start_ok;
  assign s_awready = !aw_full && !bvalid_q;
  assign s_wready  = !w_full && !bvalid_q;
  assign commit    = aw_full && w_full && !bvalid_q;
  assign s_arready = !rvalid_q;
  assign rd_fire   = s_arvalid && s_arready;
  assign rd_ctrl   = rd_fire && (ra == OFS_CTRL);
  assign start_ok  = commit && (wa == OFS_CTRL) && w_strb_q[0] && w_data_q[0]
                     && !start_bit && idle_q;

  always_comb begin
    isr_ev    = '0;
    isr_ev[0] = eng_done;
    isr_ev[1] = start_ok;
    isr_clr   = (commit && wa == OFS_ISR && w_strb_q[0]) ? w_data_q[NSRC-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    case (ra)
      OFS_CTRL: rd_mux[2:0] = {idle_q, done_bit, start_bit};
      OFS_GIE:  rd_mux[0] = gie_bit;
      OFS_IER:  rd_mux[NSRC-1:0] = ier_q;
      OFS_ISR:  rd_mux[NSRC-1:0] = isr_q;
      OFS_SCAL: rd_mux = scalar_q;
      OFS_ALO:  rd_mux = a_lo;
      OFS_AHI:  rd_mux = a_hi;
      OFS_BLO:  rd_mux = b_lo;
      OFS_BHI:  rd_mux = b_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0; w_full <= 1'b0; bvalid_q <= 1'b0; rvalid_q <= 1'b0;
      aw_addr_q <= '0; w_data_q <= '0; w_strb_q <= '0; rdata_q <= '0;
      start_bit <= 1'b0; done_bit <= 1'b0; idle_q <= 1'b0; gie_bit <= 1'b0;
      start_q <= 1'b0; ier_q <= '0; isr_q <= '0;
      scalar_q <= '0; a_lo <= '0; a_hi <= '0; b_lo <= '0; b_hi <= '0;
    end else begin
      if (s_awvalid && s_awready) begin aw_full <= 1'b1; aw_addr_q <= s_awaddr; end
      if (s_wvalid && s_wready) begin
        w_full <= 1'b1; w_data_q <= s_wdata; w_strb_q <= s_wstrb;
      end
      if (commit) begin
        aw_full <= 1'b0; w_full <= 1'b0; bvalid_q <= 1'b1;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end

      if (rd_fire) begin
        rvalid_q <= 1'b1; rdata_q <= rd_mux;
      end else if (rvalid_q && s_rready) begin
        rvalid_q <= 1'b0;
      end

      idle_q  <= eng_idle;
      start_q <= start_ok;
      if (start_ok) start_bit <= 1'b1;
      else if (eng_done) start_bit <= 1'b0;
      if (eng_done) done_bit <= 1'b1;
      else if (rd_ctrl) done_bit <= 1'b0;
      isr_q <= (isr_q & ~isr_clr) | isr_ev;

      if (commit && w_strb_q[0]) begin
        if (wa == OFS_GIE) gie_bit <= w_data_q[0];
        if (wa == OFS_IER) ier_q <= w_data_q[NSRC-1:0];
      end
      if (commit) begin
        case (wa)
          OFS_SCAL: scalar_q <= merge(scalar_q, w_data_q, w_strb_q);
          OFS_ALO:  a_lo <= merge(a_lo, w_data_q, w_strb_q);
          OFS_AHI:  a_hi <= merge(a_hi, w_data_q, w_strb_q);
          OFS_BLO:  b_lo <= merge(b_lo, w_data_q, w_strb_q);
          OFS_BHI:  b_hi <= merge(b_hi, w_data_q, w_strb_q);
          default: ;
        endcase
      end
    end
  end

  assign s_bvalid   = bvalid_q;
  assign s_bresp    = 2'b00;
  assign s_rvalid   = rvalid_q;
  assign s_rdata    = rdata_q;
  assign s_rresp    = 2'b00;
  assign eng_start  = start_q;
  assign arg_scalar = scalar_q;
  assign arg_base_a = {a_hi, a_lo};
  assign arg_base_b = {b_hi, b_lo};
  assign irq        = gie_bit && |(isr_q & ier_q);

  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ($past(idle_q) && !$past(start_bit)));
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !start_ok) |=> !start_bit);
  p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_bit);
  p_done_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !eng_done) |=> !done_bit);
  p_isr_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> isr_q[0]);
  p_bhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  p_rhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: tb/tb_kctl_regs.sv
module tb_kctl_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [11:0] s_awaddr = '0, s_araddr = '0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic eng_done = 0, eng_idle = 1;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, eng_start, irq;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, arg_scalar;
  logic [63:0] arg_base_a, arg_base_b;

  int checks = 0, fails = 0, pulses = 0, cyc = 0;

  kctl_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (eng_start) pulses <= pulses + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog R9: actual hung, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_aw(input logic [11:0] a);
    logic hs;
    s_awvalid = 1; s_awaddr = a;
    forever begin hs = s_awready; @(negedge clk); if (hs) break; end
    s_awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    logic hs;
    s_wvalid = 1; s_wdata = d; s_wstrb = s;
    forever begin hs = s_wready; @(negedge clk); if (hs) break; end
    s_wvalid = 0;
  endtask

  // order 0: together, 1: address first, 2: data first
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    @(negedge clk);
    if (order == 0) fork send_aw(a); send_w(d, s); join
    else if (order == 1) begin
      send_aw(a); repeat (2) @(negedge clk);
      chk("R9 no response before data", s_bvalid, 0); send_w(d, s);
    end else begin
      send_w(d, s); repeat (2) @(negedge clk);
      chk("R9 no response before address", s_bvalid, 0); send_aw(a);
    end
    while (!s_bvalid) @(negedge clk);
    chk("R8 bresp okay", s_bresp, 0);
    s_bready = 1; @(negedge clk); s_bready = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    logic hs;
    @(negedge clk);
    s_arvalid = 1; s_araddr = a;
    forever begin hs = s_arready; @(negedge clk); if (hs) break; end
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk("R8 rresp okay", s_rresp, 0);
    s_rready = 1; @(negedge clk); s_rready = 0;
  endtask

  task automatic finish_job();
    @(negedge clk); eng_done = 1; eng_idle = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chk("R10 bvalid", s_bvalid, 0);
    chk("R10 rvalid", s_rvalid, 0);
    chk("R10 irq", irq, 0);
    chk("R10 start pulse", eng_start, 0);
    chk("R10 scalar", arg_scalar, 0);
    chk("R10 write ready", {s_awready, s_wready}, 2'b11);
    rd(12'h000, d); chk("R4 idle after reset", d, 32'h4);
  endtask

  task automatic test_args();
    logic [31:0] d;
    wr(12'h010, 32'hAABBCCDD, 4'hF, 0);
    wr(12'h010, 32'h11223344, 4'b0101, 1);
    chk("R7 scalar strobes", arg_scalar, 32'hAA22CC44);
    wr(12'h018, 32'h89ABCDEF, 4'hF, 2);
    wr(12'h01C, 32'h01234567, 4'hF, 0);
    chk("R7 base A", arg_base_a, 64'h01234567_89ABCDEF);
    wr(12'h024, 32'h55667788, 4'hF, 1);
    wr(12'h028, 32'hFFFFFFFF, 4'b1000, 2);
    chk("R7 base B", arg_base_b, 64'hFF000000_55667788);
    rd(12'h01C, d); chk("R7 read A high", d, 32'h01234567);
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    wr(12'h040, 32'hFFFFFFFF, 4'hF, 0);
    wr(12'h014, 32'hFFFFFFFF, 4'hF, 0);
    rd(12'h040, d); chk("R8 read unmapped 0x40", d, 0);
    rd(12'h014, d); chk("R8 read unmapped 0x14", d, 0);
    rd(12'h020, d); chk("R8 read unmapped 0x20", d, 0);
    rd(12'h010, d); chk("R8 scalar untouched", d, 32'hAA22CC44);
    chk("R8 base A untouched", arg_base_a, 64'h01234567_89ABCDEF);
  endtask

  task automatic test_job();
    logic [31:0] d;
    wr(12'h008, 32'h1, 4'h1, 0);
    wr(12'h004, 32'h1, 4'h1, 0);
    chk("R6 irq idle", irq, 0);
    wr(12'h000, 32'h1, 4'h1, 0);
    eng_idle = 0;
    chk("R1 one start pulse", pulses, 1);
    chk("R6 start source masked", irq, 0);
    rd(12'h000, d); chk("R1 start bit busy", d, 32'h1);
    wr(12'h000, 32'h1, 4'h1, 2);
    chk("R2 busy start ignored", pulses, 1);
    rd(12'h00C, d); chk("R5 start status", d, 32'h2);
    wr(12'h00C, 32'h2, 4'h1, 0);
    rd(12'h00C, d); chk("R5 clear by writing 1", d, 32'h0);
    finish_job();
    chk("R6 irq on done", irq, 1);
    rd(12'h000, d); chk("R3 R4 done and idle", d, 32'h6);
    rd(12'h000, d); chk("R3 done cleared by read", d, 32'h4);
    wr(12'h00C, 32'h0, 4'h1, 0);
    chk("R5 writing 0 keeps status", irq, 1);
    wr(12'h00C, 32'h1, 4'h1, 1);
    chk("R5 R6 irq after clear", irq, 0);
    wr(12'h004, 32'h0, 4'h1, 0);
    wr(12'h008, 32'h3, 4'h1, 0);
    wr(12'h000, 32'h1, 4'h1, 0);
    eng_idle = 0;
    chk("R1 second start pulse", pulses, 2);
    chk("R6 global enable off", irq, 0);
    wr(12'h004, 32'h1, 4'h1, 0);
    chk("R6 global enable on", irq, 1);
    finish_job();
    rd(12'h00C, d); chk("R5 both sources", d, 32'h3);
    rd(12'h000, d); chk("R2 start bit cleared by done", d[0], 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_args();
    test_unmapped();
    test_job();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule